// File: doc/BRIEF.md
# Occupancy-Guided Input Port Scheduler

This block sits at one input of a two-stage load-balanced switch. In every slot it picks the head packet that the input sends to the middle port it is attached to. The choice is made from two sources. One is the occupancy vector the middle port returned in the previous slot, with one bit per output, where a set bit means the single-packet buffer for that output is full. The other is the local queue state, given as one length per output queue. A queue whose remote buffer is full is never picked, so the middle port cannot overflow. The queue for the output that the middle port serves next is preferred, so that output does not go idle.

Several requests sit above the basic policy. A pending reservation for one queue comes first. A multicast head comes next: it sends one copy to every output in its remaining fanout whose middle buffer is empty, and it is dequeued only when no destinations remain. The block holds that remaining fanout itself. When none of these requests applies, a selectable policy decides: round-robin from just after the last unicast queue served, or longest-queue-first. Every decision is registered, so a grant appears one clock after the inputs it was computed from. One clock equals one slot.

Top module: `occ_sched`

## Requirements
- R1: Queue i may receive a unicast grant only if its length is nonzero and bit i of `occ_vec` is 0. A set bit means the middle buffer for output i is full.
- R2: If no reservation is pending and the queue selected by `next_out` is eligible, that queue is granted, ahead of multicast and ahead of the policy.
- R3: In round-robin mode (`lqf_mode`=0) the grant is the first eligible queue, searching upward with wrap-around from the index just after the last unicast grant. Every unicast grant, whatever its source, moves that pointer to the granted index.
- R4: In longest-queue-first mode (`lqf_mode`=1) the eligible queue with the largest length is granted. On equal lengths the lowest index wins.
- R5: If `mc_nonempty` is 1, no reservation or urgent grant applies, and the remaining fanout overlaps the zero bits of `occ_vec`, a multicast copy is sent. This shows as `gnt_mc`=1, `gnt_idx`=0 and `dup_vec` = fanout AND NOT `occ_vec`.
- R6: After a multicast copy, the remaining fanout becomes the old fanout minus `dup_vec`. While any destinations remain, that residue replaces `mc_fanout`. `mc_deq` is 1 together with the copy that empties it. `dup_vec` is all zeros for every unicast grant.
- R7: A pending reservation (`resv_pend`=1) for an eligible queue `resv_idx` is granted with top priority. If the reserved queue is not eligible, the policy step uses longest-queue-first whatever `lqf_mode` says.
- R8: A decision appears on the outputs at the first rising clock edge after its inputs were presented, and stays there for one clock.
- R9: If nothing can be granted, `gnt_vld`, `gnt_mc`, `mc_deq` and `dup_vec` are 0 and the round-robin pointer keeps its value.
- R10: While `rst_n` is low at a clock edge, every output clears. The round-robin pointer resets so that queue 0 is searched first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lqf_mode | input | 1 | 0 = round-robin, 1 = longest-queue-first |
| occ_vec | input | N_PORTS | Occupancy bits from the middle port, 1 = full |
| q_len | input | N_PORTS*LEN_W | Local queue lengths, queue i in bits [i*LEN_W +: LEN_W] |
| next_out | input | IDX_W | Output the middle port serves next slot |
| mc_nonempty | input | 1 | Multicast queue holds a head packet |
| mc_fanout | input | N_PORTS | Full fanout of the multicast head |
| resv_pend | input | 1 | A reservation is pending for this slot |
| resv_idx | input | IDX_W | Queue named by the reservation |
| gnt_vld | output | 1 | A packet is sent this slot |
| gnt_idx | output | IDX_W | Granted unicast queue (0 for multicast) |
| gnt_mc | output | 1 | The grant is a multicast copy |
| dup_vec | output | N_PORTS | Outputs receiving the multicast copy |
| mc_deq | output | 1 | The multicast head is finished and leaves its queue |

## Verification
Every result of this block, including the grant, the copy vector, the dequeue pulse, the pointer move and the fanout residue, is due exactly one rising edge after the inputs that caused it. The bench drives each slot's inputs on a falling edge. On the next falling edge it compares the outputs with a model's prediction for that slot, and only then drives the next slot. The model carries its own round-robin pointer and fanout residue, so the effects that reach across slots are checked where they become visible: a later round-robin grant, or a later multicast copy.

// File: rtl/occ_sched_pkg.sv
// Shared types for the occupancy-guided input scheduler.
// Assumes nothing beyond a single slot clock domain.
package occ_sched_pkg;
    // Which rule produced this slot's decision, from highest to lowest rank.
    typedef enum logic [2:0] {
        SRC_NONE = 3'd0,
        SRC_RESV = 3'd1,
        SRC_URG  = 3'd2,
        SRC_MC   = 3'd3,
        SRC_POL  = 3'd4
    } src_e;
endpackage

// File: rtl/occ_sched_elig.sv
// Works out, per output queue, whether it holds a packet and whether it may be
// sent now. It may be sent only when the remote middle buffer is empty.
// Assumes q_len packs queue i in bits [i*LEN_W +: LEN_W].
module occ_sched_elig #(
    parameter int N_PORTS = 4,
    parameter int LEN_W   = 3
) (
    input  logic [N_PORTS-1:0]       occ_vec,
    input  logic [N_PORTS*LEN_W-1:0] q_len,
    output logic [N_PORTS-1:0]       elig
);
    for (genvar i = 0; i < N_PORTS; i++) begin : g_port
        // Eligible: queue nonempty and remote buffer free.
        assign elig[i] = (|q_len[i*LEN_W +: LEN_W]) & ~occ_vec[i];
    end
endmodule

// File: rtl/occ_sched_rr.sv
// Round-robin picker: returns the first eligible index after last_idx,
// searching upward with wrap-around.
// Assumes last_idx < N_PORTS.
module occ_sched_rr #(
    parameter int N_PORTS = 4,
    localparam int IDX_W  = $clog2(N_PORTS)
) (
    input  logic [N_PORTS-1:0] elig,
    input  logic [IDX_W-1:0]   last_idx,
    output logic               found,
    output logic [IDX_W-1:0]   pick
);
    // Circular scan that starts one past the last index served.
    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int k = 1; k <= N_PORTS; k++) begin
            int c;
            c = (int'(last_idx) + k) % N_PORTS;
            if (!found && elig[c]) begin
                found = 1'b1;
                pick  = c[IDX_W-1:0];
            end
        end
    end
endmodule

// File: rtl/occ_sched_lqf.sv
// Longest-queue-first picker: returns the eligible queue with the largest length.
// On equal lengths the lowest index wins.
// Assumes q_len packs queue i in bits [i*LEN_W +: LEN_W].
module occ_sched_lqf #(
    parameter int N_PORTS = 4,
    parameter int LEN_W   = 3,
    localparam int IDX_W  = $clog2(N_PORTS)
) (
    input  logic [N_PORTS-1:0]       elig,
    input  logic [N_PORTS*LEN_W-1:0] q_len,
    output logic                     found,
    output logic [IDX_W-1:0]         pick
);
    logic [LEN_W-1:0] best_len;

    // Linear scan; a strict compare keeps the lowest index on ties.
    always_comb begin
        found    = 1'b0;
        pick     = '0;
        best_len = '0;
        for (int i = 0; i < N_PORTS; i++) begin
            if (elig[i] && (!found || q_len[i*LEN_W +: LEN_W] > best_len)) begin
                found    = 1'b1;
                pick     = IDX_W'(i);
                best_len = q_len[i*LEN_W +: LEN_W];
            end
        end
    end
endmodule

// File: rtl/occ_sched.sv
// Per-input slot scheduler. The rules are ranked in this order:
// reservation, urgent queue for next_out, multicast copy, then the policy
// (round-robin or longest-queue-first).
// The decision is registered, so it appears one clock after its inputs.
// Assumes one clock per slot, resv_idx and next_out < N_PORTS,
// and an occupancy vector that is already aligned to this slot.
module occ_sched
    import occ_sched_pkg::*;
#(
    parameter int N_PORTS = 4,
    parameter int LEN_W   = 3,
    localparam int IDX_W  = $clog2(N_PORTS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     lqf_mode,
    input  logic [N_PORTS-1:0]       occ_vec,
    input  logic [N_PORTS*LEN_W-1:0] q_len,
    input  logic [IDX_W-1:0]         next_out,
    input  logic                     mc_nonempty,
    input  logic [N_PORTS-1:0]       mc_fanout,
    input  logic                     resv_pend,
    input  logic [IDX_W-1:0]         resv_idx,
    output logic                     gnt_vld,
    output logic [IDX_W-1:0]         gnt_idx,
    output logic                     gnt_mc,
    output logic [N_PORTS-1:0]       dup_vec,
    output logic                     mc_deq
);
    logic [N_PORTS-1:0] elig;
    logic               rr_found, lqf_found;
    logic [IDX_W-1:0]   rr_pick, lqf_pick;
    logic [IDX_W-1:0]   rr_last;
    logic [N_PORTS-1:0] fan_q;
    logic               fan_vld_q;
    logic [N_PORTS-1:0] act_fan, mc_hit, fan_left;
    logic               use_lqf;
    src_e               src;
    logic [IDX_W-1:0]   pick_idx;

    occ_sched_elig #(.N_PORTS(N_PORTS), .LEN_W(LEN_W)) u_elig (
        .occ_vec (occ_vec),
        .q_len   (q_len),
        .elig    (elig)
    );

    occ_sched_rr #(.N_PORTS(N_PORTS)) u_rr (
        .elig     (elig),
        .last_idx (rr_last),
        .found    (rr_found),
        .pick     (rr_pick)
    );

    occ_sched_lqf #(.N_PORTS(N_PORTS), .LEN_W(LEN_W)) u_lqf (
        .elig  (elig),
        .q_len (q_len),
        .found (lqf_found),
        .pick  (lqf_pick)
    );

    // Multicast view: a held residue wins over the raw head fanout.
    always_comb begin
        act_fan  = fan_vld_q ? fan_q : mc_fanout;
        mc_hit   = mc_nonempty ? (act_fan & ~occ_vec) : '0;
        fan_left = act_fan & occ_vec;
    end

    // Ranked decision for this slot.
    always_comb begin
        use_lqf  = resv_pend | lqf_mode;
        src      = SRC_NONE;
        pick_idx = '0;
        if (resv_pend && elig[resv_idx]) begin
            src      = SRC_RESV;
            pick_idx = resv_idx;
        end else if (elig[next_out]) begin
            src      = SRC_URG;
            pick_idx = next_out;
        end else if (|mc_hit) begin
            src      = SRC_MC;
        end else if (use_lqf ? lqf_found : rr_found) begin
            src      = SRC_POL;
            pick_idx = use_lqf ? lqf_pick : rr_pick;
        end
    end

    // Register the grant outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gnt_vld <= 1'b0;
            gnt_idx <= '0;
            gnt_mc  <= 1'b0;
            dup_vec <= '0;
            mc_deq  <= 1'b0;
        end else begin
            gnt_vld <= (src != SRC_NONE);
            gnt_idx <= (src == SRC_MC) ? '0 : pick_idx;
            gnt_mc  <= (src == SRC_MC);
            dup_vec <= (src == SRC_MC) ? mc_hit : '0;
            mc_deq  <= (src == SRC_MC) && (fan_left == '0);
        end
    end

    // Round-robin pointer follows every unicast grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_last <= IDX_W'(N_PORTS - 1);
        end else if (src == SRC_RESV || src == SRC_URG || src == SRC_POL) begin
            rr_last <= pick_idx;
        end
    end

    // Keep the multicast residue between copies.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fan_q     <= '0;
            fan_vld_q <= 1'b0;
        end else if (src == SRC_MC) begin
            fan_q     <= fan_left;
            fan_vld_q <= |fan_left;
        end
    end

    // One-hot view of the grant, for the checks below.
    logic [N_PORTS-1:0] gnt_oh;
    always_comb begin
        gnt_oh          = '0;
        gnt_oh[gnt_idx] = 1'b1;
    end

    // R1
    unicast_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_vld && !gnt_mc) |-> ((gnt_oh & $past(occ_vec)) == '0));

    // R2
    urgent_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(elig[next_out]) && !$past(resv_pend))
        |-> (gnt_vld && !gnt_mc && gnt_idx == $past(next_out)));

    // R5
    copy_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_mc |-> (dup_vec != '0 && (dup_vec & $past(occ_vec)) == '0));

    // R6
    deq_with_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mc_deq |-> (gnt_mc && gnt_vld));

    // R9
    no_dup_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gnt_vld |-> (dup_vec == '0 && !mc_deq && !gnt_mc));

    // R9
    eligible_served_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(|elig)) |-> gnt_vld);
endmodule

// File: tb/occ_sched_bench.sv
// Bench for occ_sched. The stimulus mixes directed corner cases with seeded
// random slots. A bench-side model computes the expected grant of each slot.
module occ_sched_bench;
    localparam int N  = 4;
    localparam int QW = 3;
    localparam int IW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lqf_mode = 1'b0;
    logic [N-1:0]  occ_vec = '0;
    logic [N*QW-1:0] q_len = '0;
    logic [IW-1:0] next_out = '0;
    logic          mc_nonempty = 1'b0;
    logic [N-1:0]  mc_fanout = '0;
    logic          resv_pend = 1'b0;
    logic [IW-1:0] resv_idx = '0;
    logic          gnt_vld, gnt_mc, mc_deq;
    logic [IW-1:0] gnt_idx;
    logic [N-1:0]  dup_vec;

    always #5 clk = ~clk;

    occ_sched #(.N_PORTS(N), .LEN_W(QW)) u_occ_sched (
        .clk(clk), .rst_n(rst_n), .lqf_mode(lqf_mode), .occ_vec(occ_vec),
        .q_len(q_len), .next_out(next_out), .mc_nonempty(mc_nonempty),
        .mc_fanout(mc_fanout), .resv_pend(resv_pend), .resv_idx(resv_idx),
        .gnt_vld(gnt_vld), .gnt_idx(gnt_idx), .gnt_mc(gnt_mc),
        .dup_vec(dup_vec), .mc_deq(mc_deq)
    );

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // Model state and the expected outputs of the slot just driven.
    logic [IW-1:0] m_rr = IW'(N - 1);
    logic [N-1:0]  m_fq = '0;
    logic          m_fv = 1'b0;
    logic          e_vld, e_mc, e_deq, have_exp = 1'b0;
    logic [IW-1:0] e_idx;
    logic [N-1:0]  e_dup, e_occ;
    string         e_tag;

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [QW-1:0] len_of(int i);
        return q_len[i*QW +: QW];
    endfunction

    // Prediction from the requirements for the inputs now on the ports.
    task automatic model();
        logic [N-1:0] el, fan, hit, left;
        int best;
        el = '0;
        for (int i = 0; i < N; i++) el[i] = (len_of(i) != 0) && !occ_vec[i];
        fan  = m_fv ? m_fq : mc_fanout;
        hit  = mc_nonempty ? (fan & ~occ_vec) : '0;
        left = fan & occ_vec;
        e_vld = 1'b1; e_mc = 1'b0; e_dup = '0; e_deq = 1'b0; e_idx = '0;
        e_occ = occ_vec;
        if (resv_pend && el[resv_idx]) begin
            e_idx = resv_idx; e_tag = "R7";
        end else if (el[next_out]) begin
            e_idx = next_out; e_tag = "R2";
        end else if (|hit) begin
            e_mc = 1'b1; e_dup = hit; e_deq = (left == '0);
            e_tag = e_deq ? "R6" : "R5";
            m_fq = left; m_fv = |left;
        end else if (el == '0) begin
            e_vld = 1'b0; e_tag = "R9";
        end else if (resv_pend || lqf_mode) begin
            best = -1;
            for (int i = 0; i < N; i++)
                if (el[i] && (best < 0 || len_of(i) > len_of(best))) best = i;
            e_idx = IW'(best); e_tag = resv_pend ? "R7" : "R4";
        end else begin
            best = -1;
            for (int k = 1; k <= N; k++) begin
                int c;
                c = (int'(m_rr) + k) % N;
                if (best < 0 && el[c]) best = c;
            end
            e_idx = IW'(best); e_tag = "R3";
        end
        if (e_vld && !e_mc) m_rr = e_idx;
        have_exp = 1'b1;
    endtask

    // R8: compare one falling edge after the slot's inputs were driven.
    task automatic check_prev();
        if (!have_exp) return;
        chk(e_tag, "gnt_vld", 32'(gnt_vld), 32'(e_vld));
        chk(e_tag, "gnt_mc", 32'(gnt_mc), 32'(e_mc));
        chk(e_tag, "gnt_idx", 32'(gnt_idx), 32'(e_idx));
        chk(e_tag, "dup_vec", 32'(dup_vec), 32'(e_dup));
        chk(e_tag, "mc_deq", 32'(mc_deq), 32'(e_deq));
        // R1: a unicast grant always names a queue whose remote buffer was free
        if (gnt_vld && !gnt_mc) chk("R1", "occ bit of granted", 32'(e_occ[gnt_idx]), 32'd0);
    endtask

    task automatic slot(logic md, logic [N-1:0] oc, logic [N*QW-1:0] ln,
                        logic [IW-1:0] nx, logic mn, logic [N-1:0] fo,
                        logic rp, logic [IW-1:0] ri);
        @(negedge clk);
        check_prev();
        lqf_mode = md; occ_vec = oc; q_len = ln; next_out = nx;
        mc_nonempty = mn; mc_fanout = fo; resv_pend = rp; resv_idx = ri;
        model();
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R10: outputs cleared while in reset
        chk("R10", "gnt_vld", 32'(gnt_vld), 32'd0);
        chk("R10", "dup_vec", 32'(dup_vec), 32'd0);
        chk("R10", "mc_deq", 32'(mc_deq), 32'd0);
        rst_n = 1'b1;
        // R10 / R3: the first round-robin pick after reset is queue 0, then 1
        slot(1'b0, 4'b1000, {3'd2, 3'd2, 3'd2, 3'd2}, 2'd3, 1'b0, '0, 1'b0, '0);
        slot(1'b0, 4'b1000, {3'd2, 3'd2, 3'd2, 3'd2}, 2'd3, 1'b0, '0, 1'b0, '0);
        // R9: nothing eligible, pointer holds, so next pick is queue 2
        slot(1'b0, 4'b1111, {3'd2, 3'd2, 3'd2, 3'd2}, 2'd3, 1'b0, '0, 1'b0, '0);
        slot(1'b0, 4'b1000, {3'd2, 3'd2, 3'd2, 3'd2}, 2'd3, 1'b0, '0, 1'b0, '0);
        // R4: tie on length 5 between queues 1 and 2, lowest index wins
        slot(1'b1, 4'b1000, {3'd1, 3'd5, 3'd5, 3'd3}, 2'd3, 1'b0, '0, 1'b0, '0);
        // R2: urgent queue 3 beats a longer queue
        slot(1'b1, 4'b0000, {3'd1, 3'd5, 3'd5, 3'd3}, 2'd3, 1'b0, '0, 1'b0, '0);
        // R7: reservation for queue 0 beats urgent queue 2
        slot(1'b0, 4'b0000, {3'd7, 3'd4, 3'd1, 3'd2}, 2'd2, 1'b0, '0, 1'b1, 2'd0);
        // R7: reserved queue full, longest-first used despite round-robin mode
        slot(1'b0, 4'b1001, {3'd7, 3'd4, 3'd1, 3'd2}, 2'd3, 1'b0, '0, 1'b1, 2'd0);
        // R5 then R6: a multicast head split over two slots
        slot(1'b0, 4'b0101, {3'd0, 3'd0, 3'd0, 3'd0}, 2'd0, 1'b1, 4'b1111, 1'b0, '0);
        slot(1'b0, 4'b1010, {3'd0, 3'd0, 3'd0, 3'd0}, 2'd1, 1'b1, 4'b1111, 1'b0, '0);
        // R6: a unicast grant carries a zero dup_vec
        slot(1'b0, 4'b0000, {3'd0, 3'd3, 3'd0, 3'd0}, 2'd2, 1'b0, 4'b1111, 1'b0, '0);
        // Random slots.
        for (int t = 0; t < 3000; t++) begin
            logic [N*QW-1:0] ln;
            for (int i = 0; i < N; i++)
                ln[i*QW +: QW] = ($urandom % 2 == 0) ? '0 : QW'($urandom);
            slot(1'($urandom), N'($urandom), ln, IW'($urandom),
                 ($urandom % 3 == 0), N'($urandom), ($urandom % 7 == 0), IW'($urandom));
        end
        @(negedge clk);
        check_prev();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule